// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Recency Ranking

This block caches eight virtual-to-physical page mappings for a 16-bit address space with 256-byte pages. A lookup presents a virtual address together with a read/write flag. One cycle later the block answers with exactly one of three outcomes: a translated physical address, a miss, or a protection fault. The low eight address bits are the page offset and pass through unchanged. The upper eight bits are the virtual page number. That number is compared with the tag of every slot at once.

Each slot keeps a 3-bit recency rank, and the eight ranks always form a permutation of 0..7, where 0 means most recently used. A fill writes a new mapping into the slot of rank 7. Empty slots sit at the bottom of that order, so a fill uses them before it evicts anything. A write that hits marks the slot dirty. A flush drops every mapping at once, as needed when the page table base changes. Page table walks and fault handling belong to the surrounding logic.

Top module: `tlb_fa_lru`

## Requirements
- R1: On a permitted hit, rsp_paddr is the slot's 8-bit physical page number in bits 15:8 and the request's bits 7:0 unchanged in bits 7:0.
- R2: A lookup hits only when a valid slot's tag equals req_vaddr[15:8]; when no valid slot matches it reports a miss. With rsp_valid high, exactly one of rsp_hit, rsp_miss, rsp_prot_fault is 1; with rsp_valid low, all three are 0.
- R3: A lookup is accepted when req_valid is 1 and neither fill_valid nor flush is 1. Its response appears on the outputs after the next rising clock edge. A lookup that coincides with a fill or a flush gets no response.
- R4: A read (req_write=0) needs the slot's read permit and a write (req_write=1) needs its write permit. Otherwise the block raises rsp_prot_fault, returns rsp_paddr=0, and changes neither the dirty bit nor the ranks.
- R5: A permitted write hit sets the slot's dirty bit, and a read hit leaves it unchanged. rsp_dirty gives the slot's dirty bit after the access on a hit, and 0 otherwise.
- R6: A fill (fill_valid=1, flush=0) writes fill_vpn, fill_ppn, the two permits and fill_dirty into the slot of rank 7 and marks that slot valid. A mapping already held in another slot is not disturbed.
- R7: On a permitted hit or a fill, the touched slot takes rank 0. Every slot ranked below the touched slot's old rank moves down by one, and the other slots keep their ranks. The ranks always form a permutation of 0..7.
- R8: flush=1 clears every valid bit and restores the reset ranks. It takes priority over a fill in the same cycle.
- R9: After reset all slots are invalid, slot i has rank 7-i (so fills go into slots 0,1,2,... in order), and all response outputs are 0.
- R10: On any response that is not a permitted hit, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 16 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 8 | Virtual page number to install |
| fill_ppn | input | 8 | Physical page number to install |
| fill_rd_ok | input | 1 | Read permit of the new mapping |
| fill_wr_ok | input | 1 | Write permit of the new mapping |
| fill_dirty | input | 1 | Initial dirty bit of the new mapping |
| flush | input | 1 | Invalidate all mappings |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No valid mapping for the page |
| rsp_prot_fault | output | 1 | Mapping found but access not permitted |
| rsp_paddr | output | 16 | Translated physical address |
| rsp_dirty | output | 1 | Dirty bit of the hit slot after the access |

## Verification
The checker watches every cycle for these properties: a single outcome per response, the one-cycle response timing, the pass-through of the offset on hits, a zero address on non-hits, the dirty flag after write hits, unchanged ranks on a fault, all valid bits clear after a flush, and the ranks staying a permutation. Some behaviour only shows across sequences of operations, and the bench scenarios cover it. That includes the order in which fills take empty slots, which mapping an eviction removes after recency changes, the dirty bit surviving later reads, the precedence of flush over fill, and a lookup being dropped when it collides with a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W        = 16;
  localparam int PA_W        = 16;
  localparam int OFF_W       = 8;
  localparam int VPN_W       = VA_W - OFF_W;
  localparam int PPN_W       = PA_W - OFF_W;
  localparam int NUM_ENTRIES = 8;
  localparam int RANK_W      = $clog2(NUM_ENTRIES);
  localparam int IDX_W       = $clog2(NUM_ENTRIES);

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             rd_ok;
    logic             wr_ok;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;

  // Rank a slot holds after reset or flush: slot 0 is least recent.
  function automatic logic [RANK_W-1:0] rank_at_reset(input int idx);
    return RANK_W'(NUM_ENTRIES - 1 - idx);
  endfunction
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N     = 8,
  parameter int TAG_W = 8,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [IW-1:0]           hit_idx_o
);
  logic [N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = valid_i[g] && (tag_i[g] == key_i);
    end
  endgenerate

  always_comb begin
    hit_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = IW'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/tlb_lru_rank.sv
module tlb_lru_rank #(
  parameter int N   = 8,
  localparam int RW = $clog2(N),
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][RW-1:0] rank_i,
  input  logic                 touch_en_i,
  input  logic [IW-1:0]        touch_idx_i,
  output logic [N-1:0][RW-1:0] rank_o,
  output logic [IW-1:0]        victim_idx_o
);
  localparam logic [RW-1:0] RANK_LAST = RW'(N - 1);

  logic [RW-1:0] touched_rank;
  assign touched_rank = rank_i[touch_idx_i];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rank
      always_comb begin
        rank_o[g] = rank_i[g];
        if (touch_en_i) begin
          if (IW'(g) == touch_idx_i)
            rank_o[g] = '0;
          else if (rank_i[g] < touched_rank)
            rank_o[g] = rank_i[g] + RW'(1);
        end
      end
    end
  endgenerate

  always_comb begin
    victim_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_i[i] == RANK_LAST) victim_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_rd_ok,
  input  logic              fill_wr_ok,
  input  logic              fill_dirty,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_prot_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_dirty
);
  tlb_entry_t [NUM_ENTRIES-1:0]             ent_q, ent_d;
  logic [NUM_ENTRIES-1:0][RANK_W-1:0]       rank_q, rank_d, rank_upd;
  logic [NUM_ENTRIES-1:0]                   valid_vec;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0]        tag_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_unpack
      assign valid_vec[g] = ent_q[g].valid;
      assign tag_vec[g]   = ent_q[g].vpn;
    end
  endgenerate

  // Request decode
  logic              accept;
  logic              do_fill;
  logic [VPN_W-1:0]  req_vpn;
  logic [OFF_W-1:0]  req_off;
  logic              tag_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic              perm_ok;
  logic              good_hit;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;

  assign accept  = req_valid && !fill_valid && !flush;
  assign do_fill = fill_valid && !flush;
  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  tlb_cam_match #(.N(NUM_ENTRIES), .TAG_W(VPN_W)) u_cam (
    .valid_i   (valid_vec),
    .tag_i     (tag_vec),
    .key_i     (req_vpn),
    .hit_o     (tag_hit),
    .hit_idx_o (hit_idx)
  );

  assign perm_ok   = req_write ? ent_q[hit_idx].wr_ok : ent_q[hit_idx].rd_ok;
  assign good_hit  = accept && tag_hit && perm_ok;
  assign touch_en  = good_hit || do_fill;
  assign touch_idx = do_fill ? victim_idx : hit_idx;

  tlb_lru_rank #(.N(NUM_ENTRIES)) u_rank (
    .rank_i       (rank_q),
    .touch_en_i   (touch_en),
    .touch_idx_i  (touch_idx),
    .rank_o       (rank_upd),
    .victim_idx_o (victim_idx)
  );

  // Next state of the slot array
  always_comb begin
    ent_d  = ent_q;
    rank_d = rank_upd;
    if (flush) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_d[i].valid = 1'b0;
        rank_d[i]      = rank_at_reset(i);
      end
    end else if (do_fill) begin
      ent_d[victim_idx].valid = 1'b1;
      ent_d[victim_idx].dirty = fill_dirty;
      ent_d[victim_idx].rd_ok = fill_rd_ok;
      ent_d[victim_idx].wr_ok = fill_wr_ok;
      ent_d[victim_idx].vpn   = fill_vpn;
      ent_d[victim_idx].ppn   = fill_ppn;
    end else if (good_hit && req_write) begin
      ent_d[hit_idx].dirty = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_q[i]  <= '0;
        rank_q[i] <= rank_at_reset(i);
      end
    end else begin
      ent_q  <= ent_d;
      rank_q <= rank_d;
    end
  end

  // Response next state
  logic             rsp_valid_d, rsp_hit_d, rsp_miss_d, rsp_fault_d, rsp_dirty_d;
  logic [PA_W-1:0]  rsp_paddr_d;

  always_comb begin
    rsp_valid_d = accept;
    rsp_hit_d   = good_hit;
    rsp_miss_d  = accept && !tag_hit;
    rsp_fault_d = accept && tag_hit && !perm_ok;
    rsp_paddr_d = good_hit ? {ent_q[hit_idx].ppn, req_off} : '0;
    rsp_dirty_d = good_hit && (ent_q[hit_idx].dirty || req_write);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_prot_fault <= 1'b0;
      rsp_paddr      <= '0;
      rsp_dirty      <= 1'b0;
    end else begin
      rsp_valid      <= rsp_valid_d;
      rsp_hit        <= rsp_hit_d;
      rsp_miss       <= rsp_miss_d;
      rsp_prot_fault <= rsp_fault_d;
      rsp_paddr      <= rsp_paddr_d;
      rsp_dirty      <= rsp_dirty_d;
    end
  end
endmodule

// File: rtl/tlb_fa_lru_chk.sv
module tlb_fa_lru_chk
  import tlb_pkg::*;
(
  input logic                               clk,
  input logic                               rst_n,
  input logic                               req_valid,
  input logic [VA_W-1:0]                    req_vaddr,
  input logic                               req_write,
  input logic                               fill_valid,
  input logic                               flush,
  input logic                               rsp_valid,
  input logic                               rsp_hit,
  input logic                               rsp_miss,
  input logic                               rsp_prot_fault,
  input logic [PA_W-1:0]                    rsp_paddr,
  input logic                               rsp_dirty,
  input logic [NUM_ENTRIES-1:0]             valid_vec,
  input logic [NUM_ENTRIES-1:0][RANK_W-1:0] rank_q
);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_fault}) == 1);

  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot_fault));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !fill_valid && !flush));

  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  a_r10_zero_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

  a_r5_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && $past(req_write)) |-> rsp_dirty);

  a_r4_fault_keeps_rank: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_fault |-> rank_q == $past(rank_q));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0);

  logic [NUM_ENTRIES-1:0] holds_rank [NUM_ENTRIES];
  always_comb begin
    for (int v = 0; v < NUM_ENTRIES; v++)
      for (int i = 0; i < NUM_ENTRIES; i++)
        holds_rank[v][i] = (rank_q[i] == RANK_W'(v));
  end

  genvar gv;
  generate
    for (gv = 0; gv < NUM_ENTRIES; gv++) begin : g_perm
      a_r7_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(holds_rank[gv]) == 1);
    end
  endgenerate
endmodule

bind tlb_fa_lru tlb_fa_lru_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_vaddr      (req_vaddr),
  .req_write      (req_write),
  .fill_valid     (fill_valid),
  .flush          (flush),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_miss       (rsp_miss),
  .rsp_prot_fault (rsp_prot_fault),
  .rsp_paddr      (rsp_paddr),
  .rsp_dirty      (rsp_dirty),
  .valid_vec      (valid_vec),
  .rank_q         (rank_q)
);

// File: tb/tlb_fa_lru_tb.sv
module tlb_fa_lru_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_vpn = '0;
  logic [7:0]  fill_ppn = '0;
  logic        fill_rd_ok = 1'b0;
  logic        fill_wr_ok = 1'b0;
  logic        fill_dirty = 1'b0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty;
  logic [15:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  tlb_fa_lru u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok),
    .fill_dirty(fill_dirty), .flush(flush), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot_fault(rsp_prot_fault),
    .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty)
  );

  // Outcome codes: 0 miss, 1 hit, 2 protection fault
  typedef struct packed {
    logic        is_fill;
    logic [15:0] addr;
    logic        wr;
    logic [7:0]  ppn;
    logic        rd_ok;
    logic        wr_ok;
    logic        dirty;
    logic [1:0]  exp_out;
    logic [15:0] exp_pa;
    logic        exp_dirty;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1100, 1'b0, 8'h14, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0}, // fill rw clean
    '{1'b1, 16'h2000, 1'b0, 8'h12, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0}, // fill read-only
    '{1'b1, 16'hac00, 1'b0, 8'h15, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0000, 1'b0}, // fill write-only dirty
    '{1'b0, 16'h11f0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h14f0, 1'b0}, // R1 read hit
    '{1'b0, 16'h1133, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h1433, 1'b1}, // R5 write sets dirty
    '{1'b0, 16'h1100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h1400, 1'b1}, // R5 read keeps dirty
    '{1'b0, 16'h20ae, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, 16'h0000, 1'b0}, // R4 write to read-only
    '{1'b0, 16'h20ff, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h12ff, 1'b0}, // R4 fault left clean
    '{1'b0, 16'hac10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, 16'h0000, 1'b0}, // R4 read of write-only
    '{1'b0, 16'hac10, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h1510, 1'b1}, // R6 fill dirty kept
    '{1'b0, 16'h3415, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0}  // R2 miss
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [7:0] vpn, input logic [7:0] ppn,
                         input logic rd, input logic wr, input logic dty);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_rd_ok = rd; fill_wr_ok = wr; fill_dirty = dty;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Response is registered at the edge after the request; sampled at the next negedge.
  task automatic do_lookup(input logic [15:0] a, input logic wr);
    req_valid = 1'b1; req_vaddr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [1:0] outc,
                            input logic [15:0] pa, input logic dty);
    check(req, "valid", 16'(rsp_valid), 16'h1);
    check(req, "outcome {fault,miss,hit}", 16'({rsp_prot_fault, rsp_miss, rsp_hit}),
          16'(outc == 2'd1 ? 3'b001 : outc == 2'd0 ? 3'b010 : 3'b100));
    check(req, "paddr", rsp_paddr, pa);
    check(req, "dirty", 16'(rsp_dirty), 16'(dty));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9", "rsp flags", 16'({rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty}), 16'h0);
    check("R9", "rsp_paddr", rsp_paddr, 16'h0);
    do_lookup(16'h0000, 1'b0);
    expect_rsp("R9/R2", 2'd0, 16'h0, 1'b0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_fill) begin
        do_fill(VECS[i].addr[15:8], VECS[i].ppn, VECS[i].rd_ok, VECS[i].wr_ok, VECS[i].dirty);
      end else begin
        do_lookup(VECS[i].addr, VECS[i].wr);
        expect_rsp("R1/R2/R4/R5/R10", VECS[i].exp_out, VECS[i].exp_pa, VECS[i].exp_dirty);
      end
    end

    // R3: lookup colliding with a fill gets no response; the fill still lands (R6)
    req_valid = 1'b1; req_vaddr = 16'h1100; req_write = 1'b0;
    fill_valid = 1'b1; fill_vpn = 8'h60; fill_ppn = 8'h61;
    fill_rd_ok = 1'b1; fill_wr_ok = 1'b1; fill_dirty = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    check("R3", "rsp_valid on collision", 16'(rsp_valid), 16'h0);
    do_lookup(16'h6005, 1'b0);
    expect_rsp("R6", 2'd1, 16'h6105, 1'b0);
    do_lookup(16'h11f0, 1'b0);
    expect_rsp("R6", 2'd1, 16'h14f0, 1'b1);

    // R8: flush drops everything
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_lookup(16'h11f0, 1'b0);
    expect_rsp("R8", 2'd0, 16'h0, 1'b0);
    do_lookup(16'h6005, 1'b1);
    expect_rsp("R8", 2'd0, 16'h0, 1'b0);

    // R8: flush wins over a simultaneous fill
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 8'h70; fill_ppn = 8'h71;
    fill_rd_ok = 1'b1; fill_wr_ok = 1'b1; fill_dirty = 1'b0;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    do_lookup(16'h7000, 1'b0);
    expect_rsp("R8", 2'd0, 16'h0, 1'b0);

    // R7: recency order decides eviction
    for (int k = 0; k < 8; k++) do_fill(8'(8'h40 + k), 8'(8'h80 + k), 1'b1, 1'b1, 1'b0);
    do_lookup(16'h4022, 1'b0);
    expect_rsp("R7", 2'd1, 16'h8022, 1'b0);
    do_fill(8'h50, 8'h90, 1'b1, 1'b1, 1'b0);
    do_lookup(16'h4101, 1'b0);
    expect_rsp("R7", 2'd0, 16'h0, 1'b0);
    do_lookup(16'h5033, 1'b0);
    expect_rsp("R7", 2'd1, 16'h9033, 1'b0);
    do_lookup(16'h4044, 1'b0);
    expect_rsp("R7", 2'd1, 16'h8044, 1'b0);
    do_lookup(16'h4755, 1'b1);
    expect_rsp("R7/R5", 2'd1, 16'h8755, 1'b1);
    // next victim is 0x42 (old rank order untouched by the hits above on 0x42)
    do_fill(8'h51, 8'h91, 1'b1, 1'b1, 1'b0);
    do_lookup(16'h4200, 1'b0);
    expect_rsp("R7", 2'd0, 16'h0, 1'b0);
    do_lookup(16'h4300, 1'b0);
    expect_rsp("R7", 2'd1, 16'h8300, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule